// File: doc/BRIEF.md
# DMA Write FIFO with Burst and Single Request Handshake

This block is a synchronous first-in first-out buffer that a DMA channel fills and that downstream logic drains. The block decides when the channel may move data. It compares its free space with a burst length held in a register. When the whole burst fits, it raises a burst request. When at least one word fits but a burst does not, it raises a single request. A channel set to the same burst length can then never write more than the buffer can hold.

The channel answers a raised request with a one-cycle acknowledge. From that point the block counts the words that arrive. It raises no new request until the granted number of words has been written, so one grant is never counted twice. A write that reaches a full buffer is dropped and sets a sticky error flag. Software clears that flag through the register write port, and sets the burst length through the same port.

Top module: `dma_req_fifo`

## Requirements
- R1: Each `dma_wr_valid` cycle while `level` < DEPTH stores `dma_wr_data`, and each `rd_en` cycle while `rd_valid` is high removes one word. `level` reports the number of stored words after each clock, and `rd_valid` is high exactly when `level` is nonzero.
- R2: `rd_data` always shows the oldest stored word, so words leave in the order in which they were written.
- R3: While no grant is open, `dma_burst_req` is high exactly when the free space (DEPTH minus `level`) is at least `burst_len`. This includes the case of 124 stored words with DEPTH 128 and length 4.
- R4: While no grant is open, `dma_single_req` is high exactly when the free space is at least 1 and less than `burst_len`. The two requests are never high together.
- R5: An acknowledge (`dma_req_ack` high for one cycle) while a request is high opens a grant of `burst_len` words for a burst request, or 1 word for a single request. Both requests stay low until that many `dma_wr_valid` cycles have occurred.
- R6: An acknowledge while neither request is high, or while a grant is already open, has no effect on the requests, `level` or the grant count.
- R7: A `dma_wr_valid` cycle while `level` equals DEPTH leaves the stored contents unchanged and sets `overflow_err` on the next clock.
- R8: `overflow_err` stays high until a register write with `cfg_wr_sel` = 1, which clears it regardless of `cfg_wr_data`. An overflow in the same cycle as the clear wins, and the flag stays set.
- R9: A register write with `cfg_wr_sel` = 0 loads `cfg_wr_data` into `burst_len` only while no grant is open and the value lies in 1..DEPTH. Otherwise `burst_len` is unchanged.
- R10: After reset `level` is 0, `burst_len` equals BURST_DEF, `overflow_err` is low and no grant is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_wr_valid | input | 1 | DMA writes one word this cycle |
| dma_wr_data | input | DATA_W | Word written by the DMA |
| dma_req_ack | input | 1 | DMA accepts the request that is currently raised |
| dma_burst_req | output | 1 | Room for a whole burst |
| dma_single_req | output | 1 | Room for one word but not a burst |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | 0: burst length, 1: clear overflow flag |
| cfg_wr_data | input | AW+1 | New burst length |
| burst_len | output | AW+1 | Current burst length |
| overflow_err | output | 1 | Sticky write-while-full flag |
| rd_en | input | 1 | Downstream removes the oldest word |
| rd_valid | output | 1 | At least one word stored |
| rd_data | output | DATA_W | Oldest stored word |
| level | output | AW+1 | Number of stored words |

## Verification
A wrong pointer or fill count shows on `level` one clock after the faulty write or read. The free-space compare turns that same error into a wrong `dma_burst_req` or `dma_single_req` on the same cycle. A grant counter that is off by one shows as a request that rises one write early or one write late. A burst length that is loaded when it should be rejected shows on `burst_len` one clock after the register write. The bench keeps a queue-based model, compares every output on every clock, and drives the buffer to exactly 124 words, to full, and past full.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
   typedef enum logic {
      GR_IDLE = 1'b0,
      GR_OPEN = 1'b1
   } grant_state_e;

   typedef enum logic {
      CFG_BLEN  = 1'b0,
      CFG_CLEAR = 1'b1
   } cfg_sel_e;
endpackage

// File: rtl/dreq_store.sv
module dreq_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 128,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [CW-1:0]     level,
   output logic [CW-1:0]     free_words,
   output logic              wr_overflow
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dreq_store: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("dreq_store: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [CW-1:0]     wptr, rptr;
   logic              full, wr_go, rd_go;

   assign level       = wptr - rptr;
   assign free_words  = DEPTH_C - level;
   assign full        = (level == DEPTH_C);
   assign rd_valid    = (level != '0);
   assign wr_go       = wr_valid && !full;
   assign rd_go       = rd_en && rd_valid;
   assign wr_overflow = wr_valid && full;
   assign rd_data     = mem[rptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_go) mem[wptr[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (wr_go) wptr <= wptr + 1'b1;
         if (rd_go) rptr <= rptr + 1'b1;
      end
   end

   // R1: fill count never exceeds the depth
   p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= DEPTH_C);

   // R7: a write into a full buffer does not change the fill count
   p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && full && !rd_en) |=> (level == $past(level)));
endmodule

// File: rtl/dreq_cfg.sv
module dreq_cfg
   import dreq_pkg::*;
#(
   parameter int DEPTH     = 128,
   parameter int BURST_DEF = 4,
   localparam int AW       = $clog2(DEPTH),
   localparam int CW       = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr_en,
   input  logic          cfg_wr_sel,
   input  logic [CW-1:0] cfg_wr_data,
   input  logic          grant_open,
   input  logic          overflow_evt,
   output logic [CW-1:0] burst_len,
   output logic          overflow_err
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   if (BURST_DEF < 1 || BURST_DEF > DEPTH) begin : g_bad_def
      $error("dreq_cfg: BURST_DEF must lie in 1..DEPTH");
   end

   logic blen_wr, blen_ok, clr_wr;

   assign blen_wr = cfg_wr_en && (cfg_wr_sel == CFG_BLEN);
   assign clr_wr  = cfg_wr_en && (cfg_wr_sel == CFG_CLEAR);
   assign blen_ok = (cfg_wr_data != '0) && (cfg_wr_data <= DEPTH_C) && !grant_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_len    <= CW'(BURST_DEF);
         overflow_err <= 1'b0;
      end else begin
         if (blen_wr && blen_ok) burst_len <= cfg_wr_data;
         if (overflow_evt)       overflow_err <= 1'b1;
         else if (clr_wr)        overflow_err <= 1'b0;
      end
   end

   // R9: the burst length always stays within 1..DEPTH
   p_blen_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_len != '0) && (burst_len <= DEPTH_C));

   // R9: the burst length cannot change while a grant is open
   p_blen_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grant_open |=> $stable(burst_len));

   // R8: the flag only drops through a clear write
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow_err && !clr_wr) |=> overflow_err);

   // R7: an overflow always sets the flag
   p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_evt |=> overflow_err);
endmodule

// File: rtl/dreq_grant.sv
module dreq_grant
   import dreq_pkg::*;
#(
   parameter int DEPTH = 128,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] free_words,
   input  logic [CW-1:0] burst_len,
   input  logic          req_ack,
   input  logic          wr_valid,
   output logic          burst_req,
   output logic          single_req,
   output logic          grant_open
);
   grant_state_e  state;
   logic [CW-1:0] remain;
   logic          fits_burst, fits_one;

   assign fits_burst = (free_words >= burst_len);
   assign fits_one   = (free_words != '0);
   assign grant_open = (state == GR_OPEN);
   assign burst_req  = !grant_open && fits_burst;
   assign single_req = !grant_open && fits_one && !fits_burst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= GR_IDLE;
         remain <= '0;
      end else begin
         unique case (state)
            GR_IDLE: begin
               if (req_ack && (burst_req || single_req)) begin
                  state  <= GR_OPEN;
                  remain <= burst_req ? burst_len : CW'(1);
               end
            end
            GR_OPEN: begin
               if (wr_valid) begin
                  if (remain == CW'(1)) state <= GR_IDLE;
                  remain <= remain - 1'b1;
               end
            end
            default: state <= GR_IDLE;
         endcase
      end
   end

   // R4: the two request types exclude each other
   p_req_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(burst_req && single_req));

   // R3: a burst request implies room for the whole burst
   p_burst_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
      burst_req |-> (free_words >= burst_len));

   // R4: a single request implies room for one word but not a burst
   p_single_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
      single_req |-> (free_words != '0) && (free_words < burst_len));

   // R5: an acknowledged request opens a grant
   p_grant_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_open && req_ack && (burst_req || single_req)) |=> grant_open);

   // R6: an acknowledge with no request leaves the grant closed
   p_ack_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_open && req_ack && !burst_req && !single_req) |=> !grant_open);
endmodule

// File: rtl/dma_req_fifo.sv
module dma_req_fifo #(
   parameter int DATA_W    = 32,
   parameter int DEPTH     = 128,
   parameter int BURST_DEF = 4,
   localparam int AW       = $clog2(DEPTH),
   localparam int CW       = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_wr_valid,
   input  logic [DATA_W-1:0] dma_wr_data,
   input  logic              dma_req_ack,
   output logic              dma_burst_req,
   output logic              dma_single_req,
   input  logic              cfg_wr_en,
   input  logic              cfg_wr_sel,
   input  logic [CW-1:0]     cfg_wr_data,
   output logic [CW-1:0]     burst_len,
   output logic              overflow_err,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [CW-1:0]     level
);
   logic [CW-1:0] free_words;
   logic          wr_overflow;
   logic          grant_open;

   dreq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_valid    (dma_wr_valid),
      .wr_data     (dma_wr_data),
      .rd_en       (rd_en),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data),
      .level       (level),
      .free_words  (free_words),
      .wr_overflow (wr_overflow)
   );

   dreq_cfg #(.DEPTH(DEPTH), .BURST_DEF(BURST_DEF)) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr_en    (cfg_wr_en),
      .cfg_wr_sel   (cfg_wr_sel),
      .cfg_wr_data  (cfg_wr_data),
      .grant_open   (grant_open),
      .overflow_evt (wr_overflow),
      .burst_len    (burst_len),
      .overflow_err (overflow_err)
   );

   dreq_grant #(.DEPTH(DEPTH)) u_grant (
      .clk        (clk),
      .rst_n      (rst_n),
      .free_words (free_words),
      .burst_len  (burst_len),
      .req_ack    (dma_req_ack),
      .wr_valid   (dma_wr_valid),
      .burst_req  (dma_burst_req),
      .single_req (dma_single_req),
      .grant_open (grant_open)
   );

   // R1: the valid flag agrees with the fill count
   p_valid_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == (level != '0));
endmodule

// File: tb/test_dma_req_fifo.sv
module test_dma_req_fifo;
   localparam int DATA_W = 32;
   localparam int DEPTH  = 128;
   localparam int BDEF   = 4;
   localparam int CW     = $clog2(DEPTH) + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              dma_wr_valid = 1'b0;
   logic [DATA_W-1:0] dma_wr_data = '0;
   logic              dma_req_ack = 1'b0;
   logic              dma_burst_req, dma_single_req;
   logic              cfg_wr_en = 1'b0;
   logic              cfg_wr_sel = 1'b0;
   logic [CW-1:0]     cfg_wr_data = '0;
   logic [CW-1:0]     burst_len;
   logic              overflow_err;
   logic              rd_en = 1'b0;
   logic              rd_valid;
   logic [DATA_W-1:0] rd_data;
   logic [CW-1:0]     level;

   always #10 clk = ~clk;

   dma_req_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BURST_DEF(BDEF)) i_dma_req_fifo (
      .clk(clk), .rst_n(rst_n), .dma_wr_valid(dma_wr_valid), .dma_wr_data(dma_wr_data),
      .dma_req_ack(dma_req_ack), .dma_burst_req(dma_burst_req), .dma_single_req(dma_single_req),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
      .burst_len(burst_len), .overflow_err(overflow_err), .rd_en(rd_en),
      .rd_valid(rd_valid), .rd_data(rd_data), .level(level));

   // reference model
   logic [DATA_W-1:0] mq[$];
   int  m_blen = BDEF;
   bit  m_err  = 1'b0;
   bit  m_open = 1'b0;
   int  m_rem  = 0;
   int  n_total = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;
   int  wseq    = 0;

   function automatic bit m_breq();
      return !m_open && (DEPTH - mq.size()) >= m_blen;
   endfunction
   function automatic bit m_sreq();
      return !m_open && (DEPTH - mq.size()) >= 1 && (DEPTH - mq.size()) < m_blen;
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         bit full, breq, sreq;
         full = (mq.size() == DEPTH);
         breq = m_breq();
         sreq = m_sreq();
         if (rd_en && mq.size() > 0) void'(mq.pop_front());
         if (dma_wr_valid && !full) mq.push_back(dma_wr_data);
         if (dma_wr_valid && full) m_err = 1'b1;
         else if (cfg_wr_en && cfg_wr_sel) m_err = 1'b0;
         if (cfg_wr_en && !cfg_wr_sel && !m_open && cfg_wr_data >= 1 && cfg_wr_data <= DEPTH)
            m_blen = int'(cfg_wr_data);
         if (!m_open) begin
            if (dma_req_ack && (breq || sreq)) begin
               m_open = 1'b1;
               m_rem  = breq ? m_blen : 1;
            end
         end else if (dma_wr_valid) begin
            if (m_rem == 1) m_open = 1'b0;
            m_rem = m_rem - 1;
         end
      end
   end

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(level == CW'(mq.size()), "R1", "level", level, mq.size());
         check(rd_valid == (mq.size() > 0), "R1", "rd_valid", rd_valid, mq.size() > 0);
         if (mq.size() > 0) check(rd_data == mq[0], "R2", "rd_data", rd_data, mq[0]);
         check(dma_burst_req == m_breq(), "R3", "burst_req", dma_burst_req, m_breq());
         check(dma_single_req == m_sreq(), "R4", "single_req", dma_single_req, m_sreq());
         check(overflow_err == m_err, "R7/R8", "overflow_err", overflow_err, m_err);
         check(burst_len == CW'(m_blen), "R9", "burst_len", burst_len, m_blen);
      end
   end

   task automatic step(bit wv, bit ack, bit ce, bit cs, int cd, bit rd);
      dma_wr_valid = wv;
      if (wv) begin
         wseq++;
         dma_wr_data = 32'hA5C0_0000 ^ (wseq * 32'h0101_0037);
      end
      dma_req_ack = ack;
      cfg_wr_en   = ce;
      cfg_wr_sel  = cs;
      cfg_wr_data = CW'(cd);
      rd_en       = rd;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
   endtask

   task automatic grant_and_fill(int words);
      step(0, 1, 0, 0, 0, 0);
      for (int i = 0; i < words; i++) step(1, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check(level == '0, "R10", "reset level", level, 0);
      check(burst_len == CW'(BDEF), "R10", "reset burst_len", burst_len, BDEF);
      check(overflow_err == 1'b0, "R10", "reset overflow_err", overflow_err, 0);
      check(dma_burst_req == 1'b1, "R10", "reset burst_req", dma_burst_req, 1);
      rst_n = 1'b1;
      idle(2);
      // R5: burst grant with gaps, R6: ack while grant open is ignored
      step(0, 1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0);
      idle(2);
      // R9: rejected lengths
      step(0, 0, 1, 0, 0, 0);
      step(0, 0, 1, 0, 200, 0);
      step(0, 0, 1, 0, DEPTH + 1, 0);
      step(0, 1, 0, 0, 0, 0);
      step(1, 0, 1, 0, 8, 0);
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);
      step(0, 0, 1, 0, 8, 0);
      grant_and_fill(8);
      step(0, 0, 1, 0, BDEF, 0);
      // R3: fill up to 124 words with bursts
      while (mq.size() < DEPTH - BDEF) grant_and_fill(BDEF);
      idle(1);
      check(dma_burst_req == 1'b1 && level == CW'(DEPTH - BDEF), "R3", "burst at 124",
            {dma_burst_req, level}, {1'b1, CW'(DEPTH - BDEF)});
      // R4: longer length leaves only single requests
      step(0, 0, 1, 0, 8, 0);
      while (mq.size() < DEPTH) grant_and_fill(1);
      idle(1);
      // R6: ack when full, R7: overflow writes
      step(0, 1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0);
      idle(1);
      // R8: clear, then clear racing an overflow
      step(0, 0, 1, 1, 77, 0);
      step(1, 0, 1, 1, 0, 0);
      step(0, 0, 1, 1, 0, 0);
      step(0, 0, 1, 0, BDEF, 0);
      // R1/R2: reads mixed with writes, then drain
      for (int i = 0; i < 10; i++) step(i % 2, 0, 0, 0, 0, 1);
      while (mq.size() > 0) step(0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 1);
      idle(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_total++;
         n_fail++;
         $display("FAIL watchdog (all) actual=running expected=finished");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end
endmodule